// File: doc/BRIEF.md
# Debounced ADC Window Alarm

This block watches a stream of ADC conversion results and keeps one alarm bit for each monitored channel. Every conversion arrives as a one-cycle strobe that carries a channel index and a result code. The result is compared against that channel's own upper and lower limit. A channel raises its alarm only after a programmable run of back-to-back out-of-window results. This filters out single noisy samples. Once the alarm is raised, it drops only when a result lands inside a window that has been narrowed on both sides by a programmable hysteresis margin. This stops the flag from chattering near a limit.

Each channel runs a small state machine of its own, with three states:
- ST_QUIET: no alarm, run counter at zero.
- ST_ARMING: one or more consecutive out-of-window results seen, but fewer than the trip count.
- ST_TRIPPED: alarm raised.

The transitions are:
- ARM: ST_QUIET to ST_ARMING, on an out-of-window result when the trip count is above one.
- ADVANCE: ST_ARMING to ST_ARMING, on a further out-of-window result that does not yet reach the trip count.
- TRIP: ST_QUIET or ST_ARMING to ST_TRIPPED, on the out-of-window result that completes the run.
- ABORT: ST_ARMING to ST_QUIET, on an in-window result.
- RECOVER: ST_TRIPPED to ST_QUIET, on a result inside the narrowed window.
- DISABLE: any state to ST_QUIET, whenever the channel enable is low.

Channel sequencing, interrupt routing and register access belong to the surrounding logic. The limits, trip count, hysteresis and enables arrive as plain configuration inputs.

Top module: `adcwin_alarm_top`

## Requirements
- R1: A conversion updates only the channel whose index equals `conv_chan` while `conv_valid` is high. Every other channel, and every channel in a cycle with `conv_valid` low, keeps its alarm and its run count.
- R2: A result is out of window when it is strictly greater than the channel's upper limit or strictly less than its lower limit. A result equal to either limit is in the window.
- R3: A channel's alarm goes to 1 on the Nth consecutive out-of-window result for that channel. N is the 3-bit `trip_count`, and a value of 0 acts as 1.
- R4: An in-window result arriving before the Nth out-of-window result aborts the run, so a fresh run of N is needed to raise the alarm.
- R5: An active alarm clears only on a result strictly below (upper limit minus hysteresis) and strictly above (lower limit plus hysteresis). The hysteresis is the 7-bit `hyst` input, from 0 to 127 codes.
- R6: While the alarm is active, a result inside the raw window but outside the narrowed window leaves the alarm set. Out-of-window results in that state do not advance the run count, so after a clear the next run starts from zero.
- R7: Upper limit minus hysteresis saturates at 0, and lower limit plus hysteresis saturates at full scale (4095). A threshold never wraps around.
- R8: While a channel's enable bit is low, its alarm is 0 one cycle later, its run count is zero, and its conversions have no effect.
- R9: A synchronous active-high `rst` clears every alarm bit and run count.
- R10: An alarm bit changes on the clock edge that samples the conversion strobe causing the change. The new value is visible from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| conv_valid | input | 1 | One-cycle strobe marking a new conversion result |
| conv_chan | input | CH_W (2) | Channel index of the conversion |
| conv_code | input | CODE_W (12) | Unsigned conversion result |
| lim_hi_flat | input | NUM_CH*CODE_W (48) | Upper limits; channel k in bits [k*CODE_W +: CODE_W] |
| lim_lo_flat | input | NUM_CH*CODE_W (48) | Lower limits; channel k in bits [k*CODE_W +: CODE_W] |
| trip_count | input | TRIP_W (3) | Consecutive out-of-window results needed to alarm; 0 acts as 1 |
| hyst | input | HYST_W (7) | Hysteresis margin in codes |
| chan_en | input | NUM_CH (4) | Per-channel enable; bit k enables channel k |
| alarm | output | NUM_CH (4) | Per-channel alarm; bit k belongs to channel k |

## Verification
The bench builds the block with its defaults: four channels, 12-bit codes, a 7-bit hysteresis and a 3-bit trip count. Four channels are enough to give each channel a different limit pair. One sits mid-scale, one is wide, one has its upper limit near zero, and one has its lower limit near full scale. With these pairs, both saturation directions can be reached with hysteresis values of 10 and 100. The 3-bit trip count lets the bench cover the 0-acts-as-1 case, short runs and the longest run of seven. Interleaved conversions on other channels show that runs are counted per channel.

// File: rtl/adcwin_pkg.sv
package adcwin_pkg;

    // Per-channel detector states
    typedef enum logic [1:0] {
        ST_QUIET   = 2'd0,
        ST_ARMING  = 2'd1,
        ST_TRIPPED = 2'd2
    } win_state_e;

endpackage

// File: rtl/adcwin_thresh.sv
// Narrowed-window thresholds with saturation at both ends of the code range.
module adcwin_thresh #(
    parameter int CODE_W = 12,
    parameter int HYST_W = 7
) (
    input  logic [CODE_W-1:0] lim_hi,
    input  logic [CODE_W-1:0] lim_lo,
    input  logic [HYST_W-1:0] hyst,
    output logic [CODE_W-1:0] clr_hi,
    output logic [CODE_W-1:0] clr_lo
);
    localparam int EXT_W = CODE_W + 1;

    logic [EXT_W-1:0] hyst_ext;
    logic [EXT_W-1:0] hi_diff;
    logic [EXT_W-1:0] lo_sum;

    always_comb begin
        hyst_ext = EXT_W'(hyst);
        hi_diff  = {1'b0, lim_hi} - hyst_ext;
        lo_sum   = {1'b0, lim_lo} + hyst_ext;
        // borrow out of the subtraction means the threshold would go below 0
        clr_hi   = hi_diff[EXT_W-1] ? '0 : hi_diff[CODE_W-1:0];
        // carry out of the addition means the threshold would pass full scale
        clr_lo   = lo_sum[EXT_W-1] ? '1 : lo_sum[CODE_W-1:0];
    end
endmodule

// File: rtl/adcwin_classify.sv
// Raw-window and narrowed-window comparison of one result.
module adcwin_classify #(
    parameter int CODE_W = 12
) (
    input  logic [CODE_W-1:0] code,
    input  logic [CODE_W-1:0] lim_hi,
    input  logic [CODE_W-1:0] lim_lo,
    input  logic [CODE_W-1:0] clr_hi,
    input  logic [CODE_W-1:0] clr_lo,
    output logic              out_of_range,
    output logic              well_inside
);
    always_comb begin
        out_of_range = (code > lim_hi) || (code < lim_lo);
        well_inside  = (code < clr_hi) && (code > clr_lo);
    end
endmodule

// File: rtl/adcwin_chan_fsm.sv
// Debounce and hysteresis state machine for one channel.
module adcwin_chan_fsm
    import adcwin_pkg::*;
#(
    parameter int TRIP_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              hit,
    input  logic              out_of_range,
    input  logic              well_inside,
    input  logic [TRIP_W-1:0] trip_count,
    output logic              alarm
);
    win_state_e        state_q, state_d;
    logic [TRIP_W-1:0] cnt_q, cnt_d;
    logic [TRIP_W-1:0] trip_eff;
    logic [TRIP_W-1:0] cnt_inc;

    always_comb begin
        trip_eff = (trip_count == '0) ? TRIP_W'(1) : trip_count;
        cnt_inc  = cnt_q + TRIP_W'(1);
        state_d  = state_q;
        cnt_d    = cnt_q;
        if (!enable) begin
            // DISABLE
            state_d = ST_QUIET;
            cnt_d   = '0;
        end else if (hit) begin
            unique case (state_q)
                ST_QUIET, ST_ARMING: begin
                    if (out_of_range) begin
                        if (cnt_inc >= trip_eff) begin
                            // TRIP
                            state_d = ST_TRIPPED;
                            cnt_d   = '0;
                        end else begin
                            // ARM or ADVANCE
                            state_d = ST_ARMING;
                            cnt_d   = cnt_inc;
                        end
                    end else begin
                        // ABORT (or stay quiet)
                        state_d = ST_QUIET;
                        cnt_d   = '0;
                    end
                end
                ST_TRIPPED: begin
                    if (well_inside) begin
                        // RECOVER
                        state_d = ST_QUIET;
                    end
                    cnt_d = '0;
                end
                default: begin
                    state_d = ST_QUIET;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_QUIET;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (rst) begin
            alarm <= 1'b0;
        end else begin
            alarm <= (state_d == ST_TRIPPED);
        end
    end
endmodule

// File: rtl/adcwin_alarm_top.sv
module adcwin_alarm_top #(
    parameter int NUM_CH = 4,
    parameter int CODE_W = 12,
    parameter int HYST_W = 7,
    parameter int TRIP_W = 3,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int LIM_W = NUM_CH * CODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              conv_valid,
    input  logic [CH_W-1:0]   conv_chan,
    input  logic [CODE_W-1:0] conv_code,
    input  logic [LIM_W-1:0]  lim_hi_flat,
    input  logic [LIM_W-1:0]  lim_lo_flat,
    input  logic [TRIP_W-1:0] trip_count,
    input  logic [HYST_W-1:0] hyst,
    input  logic [NUM_CH-1:0] chan_en,
    output logic [NUM_CH-1:0] alarm
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic [CODE_W-1:0] hi_w, lo_w, clr_hi_w, clr_lo_w;
        logic              hit_w, oor_w, inside_w;

        assign hi_w  = lim_hi_flat[g*CODE_W +: CODE_W];
        assign lo_w  = lim_lo_flat[g*CODE_W +: CODE_W];
        assign hit_w = conv_valid && (conv_chan == CH_W'(g));

        adcwin_thresh #(.CODE_W(CODE_W), .HYST_W(HYST_W)) thresh_i (
            .lim_hi (hi_w),
            .lim_lo (lo_w),
            .hyst   (hyst),
            .clr_hi (clr_hi_w),
            .clr_lo (clr_lo_w)
        );

        adcwin_classify #(.CODE_W(CODE_W)) classify_i (
            .code         (conv_code),
            .lim_hi       (hi_w),
            .lim_lo       (lo_w),
            .clr_hi       (clr_hi_w),
            .clr_lo       (clr_lo_w),
            .out_of_range (oor_w),
            .well_inside  (inside_w)
        );

        adcwin_chan_fsm #(.TRIP_W(TRIP_W)) fsm_i (
            .clk          (clk),
            .rst          (rst),
            .enable       (chan_en[g]),
            .hit          (hit_w),
            .out_of_range (oor_w),
            .well_inside  (inside_w),
            .trip_count   (trip_count),
            .alarm        (alarm[g])
        );
    end
endmodule

// File: rtl/adcwin_alarm_chk.sv
module adcwin_alarm_chk #(
    parameter int NUM_CH = 4,
    parameter int CODE_W = 12,
    parameter int TRIP_W = 3,
    parameter int CH_W   = 2
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     conv_valid,
    input logic [CH_W-1:0]          conv_chan,
    input logic [CODE_W-1:0]        conv_code,
    input logic [NUM_CH*CODE_W-1:0] lim_hi_flat,
    input logic [NUM_CH*CODE_W-1:0] lim_lo_flat,
    input logic [TRIP_W-1:0]        trip_count,
    input logic [NUM_CH-1:0]        chan_en,
    input logic [NUM_CH-1:0]        alarm
);
    // R9
    reset_clears_chk: assert property (@(posedge clk) rst |=> (alarm == '0));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        logic hit_c, oor_c;
        assign hit_c = conv_valid && (conv_chan == CH_W'(g));
        assign oor_c = (conv_code > lim_hi_flat[g*CODE_W +: CODE_W]) ||
                       (conv_code < lim_lo_flat[g*CODE_W +: CODE_W]);

        // R3
        rise_needs_oor_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(alarm[g]) |-> $past(hit_c && oor_c && chan_en[g]));

        // R5
        fall_needs_clear_chk: assert property (@(posedge clk) disable iff (rst)
            $fell(alarm[g]) |-> ($past(rst) || $past(!chan_en[g] || (hit_c && !oor_c))));

        // R8
        disabled_low_chk: assert property (@(posedge clk) disable iff (rst)
            !chan_en[g] |=> !alarm[g]);

        // R1
        idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (chan_en[g] && !hit_c) |=> $stable(alarm[g]));

        // R3
        single_trip_chk: assert property (@(posedge clk) disable iff (rst)
            (chan_en[g] && hit_c && oor_c && (trip_count <= TRIP_W'(1))) |=> alarm[g]);
    end
endmodule

bind adcwin_alarm_top adcwin_alarm_chk #(
    .NUM_CH (NUM_CH),
    .CODE_W (CODE_W),
    .TRIP_W (TRIP_W),
    .CH_W   (CH_W)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .conv_valid  (conv_valid),
    .conv_chan   (conv_chan),
    .conv_code   (conv_code),
    .lim_hi_flat (lim_hi_flat),
    .lim_lo_flat (lim_lo_flat),
    .trip_count  (trip_count),
    .chan_en     (chan_en),
    .alarm       (alarm)
);

// File: tb/adcwin_alarm_top_tb_top.sv
`timescale 1ns/1ps
module adcwin_alarm_top_tb_top;
    localparam int NUM_CH = 4;
    localparam int CODE_W = 12;
    localparam int HYST_W = 7;
    localparam int TRIP_W = 3;
    localparam int CH_W   = 2;
    localparam int FULL   = (1 << CODE_W) - 1;

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic                     conv_valid = 1'b0;
    logic [CH_W-1:0]          conv_chan = '0;
    logic [CODE_W-1:0]        conv_code = '0;
    logic [NUM_CH*CODE_W-1:0] lim_hi_flat;
    logic [NUM_CH*CODE_W-1:0] lim_lo_flat;
    logic [TRIP_W-1:0]        trip_count = 3'd3;
    logic [HYST_W-1:0]        hyst = 7'd10;
    logic [NUM_CH-1:0]        chan_en = '1;
    logic [NUM_CH-1:0]        alarm;

    always #4 clk = ~clk;

    int hi_tab [NUM_CH] = '{3000, 4000, 50, 4095};
    int lo_tab [NUM_CH] = '{1000, 100, 0, 4090};

    always_comb begin
        for (int k = 0; k < NUM_CH; k++) begin
            lim_hi_flat[k*CODE_W +: CODE_W] = CODE_W'(hi_tab[k]);
            lim_lo_flat[k*CODE_W +: CODE_W] = CODE_W'(lo_tab[k]);
        end
    end

    adcwin_alarm_top #(
        .NUM_CH(NUM_CH), .CODE_W(CODE_W), .HYST_W(HYST_W), .TRIP_W(TRIP_W)
    ) dut_i (
        .clk(clk), .rst(rst), .conv_valid(conv_valid), .conv_chan(conv_chan),
        .conv_code(conv_code), .lim_hi_flat(lim_hi_flat), .lim_lo_flat(lim_lo_flat),
        .trip_count(trip_count), .hyst(hyst), .chan_en(chan_en), .alarm(alarm)
    );

    typedef struct {
        logic [NUM_CH-1:0] vec;
        string             tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    int   m_cnt [NUM_CH];
    bit   m_alm [NUM_CH];

    function automatic logic [NUM_CH-1:0] model_vec();
        logic [NUM_CH-1:0] v;
        for (int k = 0; k < NUM_CH; k++) v[k] = m_alm[k];
        return v;
    endfunction

    function automatic void model_clear_all();
        for (int k = 0; k < NUM_CH; k++) begin
            m_cnt[k] = 0;
            m_alm[k] = 1'b0;
        end
    endfunction

    // Reference model of one conversion, written from the requirements
    function automatic void model_conv(int ch, int code);
        int neff, hi_t, lo_t;
        bit oor;
        if (!chan_en[ch]) return;
        neff = (trip_count == 0) ? 1 : int'(trip_count);
        hi_t = (hi_tab[ch] > int'(hyst)) ? hi_tab[ch] - int'(hyst) : 0;
        lo_t = (lo_tab[ch] + int'(hyst) > FULL) ? FULL : lo_tab[ch] + int'(hyst);
        oor  = (code > hi_tab[ch]) || (code < lo_tab[ch]);
        if (!m_alm[ch]) begin
            if (oor) begin
                m_cnt[ch]++;
                if (m_cnt[ch] >= neff) begin
                    m_alm[ch] = 1'b1;
                    m_cnt[ch] = 0;
                end
            end else begin
                m_cnt[ch] = 0;
            end
        end else if ((code < hi_t) && (code > lo_t)) begin
            m_alm[ch] = 1'b0;
        end
    endfunction

    // Driver: one conversion strobe, expected result pushed after the sampling edge
    task automatic convert(int ch, int code, string tag);
        exp_t e;
        @(negedge clk);
        conv_valid = 1'b1;
        conv_chan  = CH_W'(ch);
        conv_code  = CODE_W'(code);
        model_conv(ch, code);
        @(posedge clk);
        e.vec = model_vec();
        e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        conv_valid = 1'b0;
    endtask

    task automatic set_en(logic [NUM_CH-1:0] v, string tag);
        exp_t e;
        @(negedge clk);
        chan_en = v;
        for (int k = 0; k < NUM_CH; k++) begin
            if (!v[k]) begin
                m_cnt[k] = 0;
                m_alm[k] = 1'b0;
            end
        end
        @(posedge clk);
        e.vec = model_vec();
        e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
    endtask

    task automatic direct_check(logic [NUM_CH-1:0] exp_v, string tag);
        checks++;
        if (alarm !== exp_v) begin
            errors++;
            $display("FAIL %s: alarm actual=%b expected=%b", tag, alarm, exp_v);
        end
    endtask

    // Monitor: compares each expected item after the edge that produced it
    initial begin
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (alarm !== e.vec) begin
                    errors++;
                    $display("FAIL %s: alarm actual=%b expected=%b", e.tag, alarm, e.vec);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        model_clear_all();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        direct_check('0, "R9 reset state");

        // Debounce with trip count 3, interleaved channels
        trip_count = 3'd3;
        convert(0, 3001, "R3 first out-of-window, no alarm");
        convert(0, 3001, "R3 second out-of-window, no alarm");
        convert(0, 2000, "R4 in-window aborts run");
        convert(0, 3001, "R4 run restarted, one");
        convert(0, 3001, "R4 run restarted, two");
        convert(1, 2000, "R1 other channel does not disturb run");
        convert(0, 999,  "R3 third consecutive (below lower) trips");

        // Limit equality and trip count 0
        trip_count = 3'd0;
        convert(1, 4000, "R2 code equal to upper limit is in window");
        convert(1, 100,  "R2 code equal to lower limit is in window");
        convert(1, 4001, "R3 trip count 0 acts as 1");

        // Hysteresis on channel 0: narrowed window 1010..2990 exclusive
        convert(0, 2995, "R6 band result keeps alarm");
        convert(0, 2990, "R5 equal to narrowed upper keeps alarm");
        convert(0, 1010, "R5 equal to narrowed lower keeps alarm");
        convert(0, 2989, "R5 inside narrowed window clears");

        // Counter is not advanced while alarmed
        trip_count = 3'd2;
        convert(1, 4050, "R6 out-of-window while alarmed");
        convert(1, 3995, "R6 band keeps alarm");
        convert(1, 3000, "R5 clear channel 1");
        convert(1, 4050, "R6 run restarts from zero after clear");
        convert(1, 4050, "R3 second of two trips");

        // Saturated thresholds
        trip_count = 3'd0;
        hyst       = 7'd100;
        convert(2, 60,   "R3 channel 2 trips");
        convert(2, 200,  "R7 upper threshold saturates at zero, no clear");
        convert(2, 10,   "R7 channel 2 stays alarmed");
        convert(3, 4000, "R3 channel 3 trips");
        convert(3, 2000, "R7 lower threshold saturates at full scale, no clear");

        // Enable behaviour
        set_en(4'b1011, "R8 disable drops channel 2 alarm");
        convert(2, 60,   "R8 conversion on disabled channel ignored");
        trip_count = 3'd2;
        set_en(4'b1111, "R8 re-enable channel 2 stays clear");
        convert(0, 3001, "R8 run of one on channel 0");
        set_en(4'b1110, "R8 disable clears channel 0 run");
        set_en(4'b1111, "R8 re-enable channel 0");
        convert(0, 3001, "R8 run restarted from zero after disable");

        // Longest run
        trip_count = 3'd7;
        convert(0, 2000, "R4 abort channel 0 run");
        for (int i = 1; i < 7; i++) convert(0, 3100, "R3 run of seven, not yet");
        convert(0, 3100, "R3 seventh consecutive trips");

        // Latency: alarm changes on the sampling edge, not before
        @(negedge clk);
        conv_valid = 1'b1;
        conv_chan  = 2'd0;
        conv_code  = 12'd2000;
        #1;
        direct_check(model_vec(), "R10 alarm unchanged before sampling edge");
        model_conv(0, 2000);
        @(negedge clk);
        conv_valid = 1'b0;
        direct_check(model_vec(), "R10 alarm cleared right after sampling edge");

        // Mid-run reset
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model_clear_all();
        direct_check('0, "R9 reset clears all alarms");

        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule